// File: doc/BRIEF.md
# Panel Timing Generator with Cross-Chip Sync Check

This block produces the row and column timing for a display panel built from several cascaded column-driver chips. Exactly one chip runs as the timing source. It divides an oscillator tick, which enters as a one-cycle clock enable, into three things: a column strobe, a frame marker that opens each half frame, and two level-select lines for the row drivers. These lines step through a fixed 16-step pattern, one step per strobe.

Every other chip runs as a follower. A follower keeps its own copy of the level-select pattern and steps it on each strobe it receives. When the incoming frame marker rises, the follower compares the source's level-select lines with its own copy. If they differ, it pulls a shared refresh line. Every chip that sees this line clears its timing state, which brings the whole panel back into phase.

After a power-up reset or a refresh, each chip keeps the display dark for four frames. This holds even when the external display enable is high.

Top module: `lcd_sync_timing`

## Requirements
- R1: While reset is asserted and until the first oscillator tick after it, the chip shows stbOut=0, frmOut=1, l1Out=1, l2Out=1, dispEnOut=0 and refreshDrive=0.
- R2: In source mode (masterMode=1), each cycle with oscEn=1 toggles stbOut, so the strobe is high for one tick and low for one tick. Cycles with oscEn=0 leave all timing unchanged.
- R3: In source mode, frmOut is 1 for exactly the first strobe period of each half frame. A half frame is 121 strobes (242 ticks), so a frame is 484 ticks. frmOut rises on the same tick on which stbOut falls.
- R4: The level-select lines are indexed by the number of completed strobes modulo 16, starting from index 0 after reset. Indexed from 0 on the left, l1Out follows 1111111100000000 and l2Out follows 1010010101011010. The sequence runs on across half-frame boundaries.
- R5: After reset, dispEnOut stays 0 until 8 half frames (4 frames, 1936 ticks in source mode) have completed. From then on it equals dispEnIn.
- R6: In follower mode (masterMode=0), frmOut and stbOut stay 0 and oscEn does not advance the sequence. The follower's own sequence steps once per falling edge of stbIn and is shown on l1Out/l2Out.
- R7: In follower mode, on the second clock edge after frmIn is first seen high, the chip compares {l1In,l2In} with its own {l1Out,l2Out}. A difference raises refreshDrive. Matching values never raise it.
- R8: Once raised, refreshDrive stays high for exactly two oscEn ticks, which is one strobe period, and then drops. No new comparison starts while it is high.
- R9: While refreshReqIn is 1, the chip clears its strobe counter, its sequence index and its dark-frame count, and dispEnOut is 0. After release, source timing restarts from tick 0 and the four dark frames begin again.
- R10: In follower mode, the four dark frames are counted as 8 rising edges of frmIn. A frmIn that is already high when reset or refresh ends does not count as an edge.
- R11: dispEnIn=0 forces dispEnOut to 0 in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| oscEn | input | 1 | Oscillator tick, one cycle wide |
| masterMode | input | 1 | 1 = timing source, 0 = follower |
| dispEnIn | input | 1 | External display enable, 1 = display allowed |
| frmIn | input | 1 | Frame marker received from the source chip |
| stbIn | input | 1 | Column strobe received from the source chip |
| l1In | input | 1 | Source chip's first level-select line |
| l2In | input | 1 | Source chip's second level-select line |
| refreshReqIn | input | 1 | State of the shared refresh line, 1 = some chip is pulling it |
| frmOut | output | 1 | Frame marker (source mode only) |
| stbOut | output | 1 | Column strobe (source mode only) |
| l1Out | output | 1 | First level-select line from this chip's sequence |
| l2Out | output | 1 | Second level-select line from this chip's sequence |
| refreshDrive | output | 1 | 1 = this chip pulls the shared refresh line |
| dispEnOut | output | 1 | Display enable for the drive stage, 1 = on |

## Verification
In source mode each timing output comes from a register that a tick updates. Its new value is therefore due at the first falling clock edge after that tick, and the bench counts ticks and samples there, also when ticks are spaced out with idle cycles. A follower's step shows half a cycle after the clock edge that sees the received strobe fall. A mismatch shows on refreshDrive one edge after that, at the compare edge. The bench therefore holds the corrupted level-select values over both edges and expects the refresh request exactly at the second. The two-tick refresh hold, the restart of the dark-frame count and the enable turning on at tick 1936 are each checked on the exact cycle on which they are due.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  // Strobes the control half hands to the datapath each cycle
  typedef struct packed {
    logic clear;     // shared refresh line active: internal reset
    logic seqStep;   // advance level-select sequence
    logic halfDone;  // one half frame completed
    logic checkNow;  // compare source lines against own copy
  } lcdt_strb_t;

  localparam int SEQ_LEN = 16;
  // index 0 held in the MSB
  localparam logic [SEQ_LEN-1:0] L1_SEQ = 16'b1111_1111_0000_0000;
  localparam logic [SEQ_LEN-1:0] L2_SEQ = 16'b1010_0101_0101_1010;

endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
#(
  parameter int STROBES_PER_HALF = 121
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscEn,
  input  logic       masterMode,
  input  logic       refreshReqIn,
  input  logic       refreshActive,
  input  logic       frmIn,
  input  logic       stbIn,
  output logic       frmOut,
  output logic       stbOut,
  output lcdt_strb_t ctlStrb
);

  localparam int CW = $clog2(STROBES_PER_HALF);
  localparam logic [CW-1:0] LAST_STB = CW'(STROBES_PER_HALF - 1);

  logic          stbHi;
  logic [CW-1:0] stbCnt;
  logic          frmPrev;
  logic          stbPrev;
  logic          checkPend;

  logic masterTick;
  logic strobeEnd;
  logic lastStrobe;
  logic frmRise;
  logic stbFall;

  assign masterTick = masterMode & oscEn & ~refreshReqIn;
  assign strobeEnd  = masterTick & stbHi;
  assign lastStrobe = (stbCnt == LAST_STB);
  assign frmRise    = ~masterMode & frmIn & ~frmPrev;
  assign stbFall    = ~masterMode & ~stbIn & stbPrev;

  // source-mode divider: strobe phase and strobe-in-half-frame counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbHi  <= 1'b0;
      stbCnt <= '0;
    end else if (refreshReqIn) begin
      stbHi  <= 1'b0;
      stbCnt <= '0;
    end else if (masterTick) begin
      stbHi <= ~stbHi;
      if (stbHi) stbCnt <= lastStrobe ? '0 : stbCnt + 1'b1;
    end
  end

  // edge detectors run through refresh so edges stay well defined
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frmPrev <= 1'b1;
      stbPrev <= 1'b0;
    end else begin
      frmPrev <= frmIn;
      stbPrev <= stbIn;
    end
  end

  // compare one edge after the frame rise, once the own step has landed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             checkPend <= 1'b0;
    else if (refreshReqIn) checkPend <= 1'b0;
    else                   checkPend <= frmRise & ~refreshActive;
  end

  assign ctlStrb = '{
    clear:    refreshReqIn,
    seqStep:  masterMode ? strobeEnd : (stbFall & ~refreshReqIn),
    halfDone: masterMode ? (strobeEnd & lastStrobe) : (frmRise & ~refreshReqIn),
    checkNow: checkPend & ~refreshActive & ~refreshReqIn
  };

  assign stbOut = masterMode & stbHi;
  assign frmOut = masterMode & (stbCnt == '0);

  // R2: every accepted tick flips the strobe
  p_strobe_toggle_r2: assert property (@(posedge clk) disable iff (!rstN)
    masterMode && oscEn && !refreshReqIn |=> stbOut != $past(stbOut));

  // R3: a frame marker opens on a strobe falling edge
  p_frame_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frmOut) && !$past(refreshReqIn) |-> $fell(stbOut));

  // R6: a follower only steps after a received strobe was high
  p_slave_step_needs_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode && !stbIn |=> !ctlStrb.seqStep);

endmodule

// File: rtl/lcdt_dp.sv
module lcdt_dp
  import lcdt_pkg::*;
#(
  parameter int OFF_FRAMES = 4,
  parameter int HOLD_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscEn,
  input  lcdt_strb_t ctlStrb,
  input  logic       l1In,
  input  logic       l2In,
  input  logic       dispEnIn,
  output logic       l1Out,
  output logic       l2Out,
  output logic       refreshDrive,
  output logic       dispEnOut
);

  localparam int OFF_HALVES = 2 * OFF_FRAMES;
  localparam int OW = $clog2(OFF_HALVES + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int SW = $clog2(SEQ_LEN);
  localparam logic [SW-1:0] SEQ_TOP  = SW'(SEQ_LEN - 1);
  localparam logic [OW-1:0] OFF_DONE = OW'(OFF_HALVES);
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD_TICKS - 1);

  logic [SW-1:0] seqIdx;
  logic [OW-1:0] offCnt;
  logic [HW-1:0] holdCnt;
  logic          mismatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                seqIdx <= '0;
    else if (ctlStrb.clear)   seqIdx <= '0;
    else if (ctlStrb.seqStep) seqIdx <= seqIdx + 1'b1;
  end

  assign l1Out = L1_SEQ[SEQ_TOP - seqIdx];
  assign l2Out = L2_SEQ[SEQ_TOP - seqIdx];

  // dark-frame counter, saturates at the enable point
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        offCnt <= '0;
    else if (ctlStrb.clear)                           offCnt <= '0;
    else if (ctlStrb.halfDone && offCnt != OFF_DONE)  offCnt <= offCnt + 1'b1;
  end

  assign dispEnOut = dispEnIn & (offCnt == OFF_DONE) & ~ctlStrb.clear;

  assign mismatch = ctlStrb.checkNow & ({l1In, l2In} != {l1Out, l2Out});

  // refresh request: survives the internal reset it causes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refreshDrive <= 1'b0;
      holdCnt      <= '0;
    end else if (!refreshDrive) begin
      holdCnt <= '0;
      if (mismatch) refreshDrive <= 1'b1;
    end else if (oscEn) begin
      if (holdCnt == HOLD_END) refreshDrive <= 1'b0;
      else                     holdCnt <= holdCnt + 1'b1;
    end
  end

  // R4: the sequence only moves on a step or a clear from control
  p_seq_step_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(seqIdx) |-> $past(ctlStrb.seqStep) || $past(ctlStrb.clear));

  // R8: a refresh request is never a single cycle
  p_refresh_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refreshDrive) |=> refreshDrive);

  // R9: display still dark right after the refresh line releases
  p_dark_after_refresh_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlStrb.clear) |-> !dispEnOut);

endmodule

// File: rtl/lcd_sync_timing.sv
module lcd_sync_timing
  import lcdt_pkg::*;
#(
  parameter int STROBES_PER_HALF = 121,
  parameter int OFF_FRAMES       = 4,
  parameter int HOLD_TICKS       = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic oscEn,
  input  logic masterMode,
  input  logic dispEnIn,
  input  logic frmIn,
  input  logic stbIn,
  input  logic l1In,
  input  logic l2In,
  input  logic refreshReqIn,
  output logic frmOut,
  output logic stbOut,
  output logic l1Out,
  output logic l2Out,
  output logic refreshDrive,
  output logic dispEnOut
);

  lcdt_strb_t ctlStrb;

  lcdt_ctrl #(
    .STROBES_PER_HALF(STROBES_PER_HALF)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .oscEn        (oscEn),
    .masterMode   (masterMode),
    .refreshReqIn (refreshReqIn),
    .refreshActive(refreshDrive),
    .frmIn        (frmIn),
    .stbIn        (stbIn),
    .frmOut       (frmOut),
    .stbOut       (stbOut),
    .ctlStrb      (ctlStrb)
  );

  lcdt_dp #(
    .OFF_FRAMES(OFF_FRAMES),
    .HOLD_TICKS(HOLD_TICKS)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .oscEn       (oscEn),
    .ctlStrb     (ctlStrb),
    .l1In        (l1In),
    .l2In        (l2In),
    .dispEnIn    (dispEnIn),
    .l1Out       (l1Out),
    .l2Out       (l2Out),
    .refreshDrive(refreshDrive),
    .dispEnOut   (dispEnOut)
  );

endmodule

// File: tb/lcd_sync_timing_tb.sv
`timescale 1ns/1ps
module lcd_sync_timing_tb_top;

  logic clk = 1'b0;
  logic rstN, oscEn, masterMode, dispEnIn;
  logic frmIn, stbIn, l1In, l2In, forceReq;
  logic frmOut, stbOut, l1Out, l2Out, refreshDrive, dispEnOut;
  logic lineReq;

  int total = 0;
  int bad   = 0;

  localparam int HALF = 121;
  localparam int DARK_TICKS = 1936;
  localparam logic [15:0] L2_REF = 16'b1010010101011010;

  always #4 clk = ~clk;

  // shared refresh line modelled as the OR of all pullers
  assign lineReq = refreshDrive | forceReq;

  lcd_sync_timing dut_i (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .masterMode(masterMode),
    .dispEnIn(dispEnIn), .frmIn(frmIn), .stbIn(stbIn), .l1In(l1In), .l2In(l2In),
    .refreshReqIn(lineReq), .frmOut(frmOut), .stbOut(stbOut), .l1Out(l1Out),
    .l2Out(l2Out), .refreshDrive(refreshDrive), .dispEnOut(dispEnOut)
  );

  function automatic bit refL1(int i);
    return (i % 16) < 8;
  endfunction

  function automatic bit refL2(int i);
    return L2_REF[15 - (i % 16)];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_slave(int tm, bit corrupt);
    stbIn = tm[0];
    frmIn = ((tm / 2) % HALF) == 0;
    l1In  = refL1(tm / 2) ^ corrupt;
    l2In  = refL2(tm / 2);
  endtask

  task automatic do_reset(bit mode);
    rstN = 1'b0; masterMode = mode; oscEn = 1'b0; dispEnIn = 1'b1; forceReq = 1'b0;
    drive_slave(0, 1'b0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic check_master(int t);
    int s = t / 2;
    check(stbOut == t[0], "R2 stbOut", int'(stbOut), t % 2);
    check(frmOut == ((s % HALF) == 0), "R3 frmOut", int'(frmOut), int'((s % HALF) == 0));
    check(l1Out == refL1(s), "R4 l1Out", int'(l1Out), int'(refL1(s)));
    check(l2Out == refL2(s), "R4 l2Out", int'(l2Out), int'(refL2(s)));
    check(dispEnOut == (t >= DARK_TICKS), "R5 dispEnOut", int'(dispEnOut), int'(t >= DARK_TICKS));
    check(refreshDrive == 1'b0, "R7 refreshDrive", int'(refreshDrive), 0);
  endtask

  task automatic run_master(int nTicks, bit gapped);
    int t = 0;
    int n = 0;
    while (t < nTicks) begin
      oscEn = gapped ? ((n % 3) != 2) : 1'b1;
      @(negedge clk);
      if (oscEn) t++;
      check_master(t);
      n++;
    end
    oscEn = 1'b0;
  endtask

  task automatic check_slave(int tm);
    int s = tm / 2;
    check(l1Out == refL1(s), "R6 l1Out", int'(l1Out), int'(refL1(s)));
    check(l2Out == refL2(s), "R6 l2Out", int'(l2Out), int'(refL2(s)));
    check(frmOut == 1'b0 && stbOut == 1'b0, "R6 quiet", int'({frmOut, stbOut}), 0);
    check(refreshDrive == 1'b0, "R7 no false refresh", int'(refreshDrive), 0);
    check(dispEnOut == (tm >= DARK_TICKS), "R10 dispEnOut", int'(dispEnOut), int'(tm >= DARK_TICKS));
  endtask

  task automatic t_reset_state();
    do_reset(1'b1);
    @(negedge clk);
    check(stbOut == 0, "R1 stbOut", int'(stbOut), 0);
    check(frmOut == 1, "R1 frmOut", int'(frmOut), 1);
    check(l1Out == 1 && l2Out == 1, "R1 l1/l2", int'({l1Out, l2Out}), 3);
    check(dispEnOut == 0, "R1 dispEnOut", int'(dispEnOut), 0);
    check(refreshDrive == 0, "R1 refreshDrive", int'(refreshDrive), 0);
  endtask

  task automatic t_master_plain();
    do_reset(1'b1);
    run_master(DARK_TICKS + 6, 1'b0);
    // R11: enable input gates the output with no delay
    dispEnIn = 1'b0; #1;
    check(dispEnOut == 0, "R11 off", int'(dispEnOut), 0);
    dispEnIn = 1'b1; #1;
    check(dispEnOut == 1, "R11 on", int'(dispEnOut), 1);
  endtask

  task automatic t_master_gapped();
    do_reset(1'b1);
    run_master(DARK_TICKS + 4, 1'b1);  // R2 idle cycles freeze timing
  endtask

  task automatic t_master_refresh();
    do_reset(1'b1);
    run_master(300, 1'b0);
    forceReq = 1'b1; oscEn = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(stbOut == 0 && frmOut == 1, "R9 cleared strobe", int'({stbOut, frmOut}), 1);
      check(l1Out == 1 && l2Out == 1, "R9 cleared seq", int'({l1Out, l2Out}), 3);
      check(dispEnOut == 0, "R9 dark", int'(dispEnOut), 0);
    end
    forceReq = 1'b0;
    run_master(DARK_TICKS + 2, 1'b0);  // R9 restart from tick 0
  endtask

  task automatic t_slave();
    int tm = 0;
    do_reset(1'b0);
    oscEn = 1'b1;
    for (int n = 0; tm < 2177; n++) begin
      if (!(n >= 100 && n < 106)) tm++;  // R6 frozen inputs, ticks still run
      drive_slave(tm, 1'b0);
      @(negedge clk);
      check_slave(tm);
    end
    // corrupt the source's first line over the frame rise at 2178
    drive_slave(2178, 1'b1);
    @(negedge clk);
    check(refreshDrive == 0, "R7 not before compare", int'(refreshDrive), 0);
    drive_slave(2179, 1'b1);
    @(negedge clk);
    check(refreshDrive == 1, "R7 mismatch raises", int'(refreshDrive), 1);
    drive_slave(0, 1'b0);
    @(negedge clk);
    check(refreshDrive == 1, "R8 second tick", int'(refreshDrive), 1);
    check(l1Out == 1 && l2Out == 1, "R9 follower cleared", int'({l1Out, l2Out}), 3);
    check(dispEnOut == 0, "R9 dark", int'(dispEnOut), 0);
    drive_slave(0, 1'b0);
    @(negedge clk);
    check(refreshDrive == 0, "R8 released", int'(refreshDrive), 0);
    tm = 0;
    while (tm < DARK_TICKS + 4) begin
      tm++;
      drive_slave(tm, 1'b0);
      @(negedge clk);
      check_slave(tm);  // R10 dark count restarted
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_master_plain();
    t_master_gapped();
    t_master_refresh();
    t_slave();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule